// File: doc/BRIEF.md
# CAN Acceptance Filter Matcher

This block decides whether a received CAN frame is kept. It compares the frame's identifier fields with 14 filter banks. The fields are the 11-bit base identifier, the 18-bit identifier extension, the extended-format flag and the remote-request flag. Each bank has an enable bit, a target receive queue, a match style (masked compare or exact-identifier list) and a width (one 32-bit filter or two 16-bit filters). Each bank also holds two 32-bit pattern words. Software loads all of these over a simple write port while a global setup bit is set.

Filter numbers are assigned separately for each of the two receive queues. Each count starts at zero and walks the banks of that queue in ascending bank order. A disabled bank still uses its numbers in the count. When several filters hit, one winner is picked: wider filters first, then list style over masked style, then the lower number. One clock cycle after the frame strobe, the block presents a result pulse with the accept flag, the queue and an 8-bit filter number.

Top module: `can_accept_filter`

## Requirements
- R1: After reset, setup mode is on and resValid, resAccept, resFifo and resMatchNum are 0. A write to address 0 copies wrData bit 0 into setup mode.
- R2: Enable (addr 1), queue (addr 2), style (addr 3, 1 = list), width (addr 4, 1 = 32-bit) use bit b for bank b. Pattern words of bank b are at 32+2b (word A) and 33+2b (word B). Writes to these addresses are ignored while setup mode is off.
- R3: A frame strobe on frmValid at a clock edge gives resValid high for exactly the next cycle, with the result for that frame.
- R4: In 32-bit masked style, the frame word is {base id[31:21], extension[20:3], extended flag[2], remote flag[1], 0[0]}. The filter hits when the frame word equals word A at every bit where word B is 1.
- R5: In 32-bit list style, word A and word B are each an exact identifier in the 32-bit frame word layout. This gives two filters, numbered base and base+1.
- R6: In 16-bit masked style, the frame word is {base id[15:5], remote flag[4], extended flag[3], extension bits 17:15 [2:0]}. Each pattern word holds an identifier in bits 15:0 and its mask in bits 31:16. Word A is filter base and word B is filter base+1.
- R7: In 16-bit list style, the four exact identifiers are A[15:0], A[31:16], B[15:0] and B[31:16]. They are numbered base to base+3 in that order.
- R8: A bank uses 1, 2, 2 or 4 numbers for 32-bit masked, 32-bit list, 16-bit masked or 16-bit list style. Numbering restarts at 0 for each queue, follows ascending bank order and counts disabled banks, which never hit.
- R9: Among several hits, a 32-bit filter beats any 16-bit filter.
- R10: At equal width, a list-style filter beats a masked-style filter.
- R11: At equal width and style, the lower filter number wins. On a full tie, queue 0 wins.
- R12: With no enabled hit, resAccept, resFifo and resMatchNum are all 0 in the result cycle.
- R13: While setup mode is on, every frame yields resAccept = 0 with resFifo and resMatchNum at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 6 | Register write address |
| wrData | input | 32 | Register write data |
| frmValid | input | 1 | Frame identifier strobe |
| frmStdId | input | 11 | Base identifier |
| frmExtId | input | 18 | Identifier extension |
| frmIde | input | 1 | Extended-format flag |
| frmRtr | input | 1 | Remote-request flag |
| resValid | output | 1 | Result pulse |
| resAccept | output | 1 | Frame accepted |
| resFifo | output | 1 | Target receive queue |
| resMatchNum | output | 8 | Winning filter number |

## Verification
A wrong per-queue running count shows up in the first accepted result. That result reports a filter number shifted by the size of a misjudged bank, and the effect appears only for banks placed after the faulty one. A wrong priority choice shows up as a different queue or number, in the same cycle as the resValid pulse of a frame that hits several filters. A stale setup bit or a leaked write shows up at the next frame, as an unexpected accept or a changed winner. The test frames are therefore built to hit two to four filters at once, and the banks are ordered so that each kind of miscount lands in a distinct number.

// File: rtl/can_flt_pkg.sv
`timescale 1ns/1ps
package can_flt_pkg;
  parameter int unsigned NUM_BANKS = 14;
  parameter int unsigned STD_W     = 11;
  parameter int unsigned EXT_W     = 18;
  parameter int unsigned DATA_W    = 32;
  parameter int unsigned ADDR_W    = 6;
  parameter int unsigned NUM_W     = 8;
  parameter int unsigned DATA_BASE = 32;

  localparam int unsigned SLOTS      = 4;
  localparam int unsigned DREG_NUM   = 2 * NUM_BANKS;
  localparam int unsigned DREG_SEL_W = $clog2(DREG_NUM);
  localparam int unsigned MAX_SLOTS  = SLOTS * NUM_BANKS;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_EN    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_FIFO  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ADDR_STYLE = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] ADDR_WIDTH = ADDR_W'(4);

  typedef enum logic [1:0] {
    CLS_M16 = 2'd0,
    CLS_L16 = 2'd1,
    CLS_M32 = 2'd2,
    CLS_L32 = 2'd3
  } fltClass_t;

  typedef struct packed {
    logic                  enWe;
    logic                  fifoWe;
    logic                  styleWe;
    logic                  widthWe;
    logic                  dataWe;
    logic [DREG_SEL_W-1:0] dataSel;
    logic                  evalStb;
    logic                  cfgOpen;
  } fltStrb_t;
endpackage

// File: rtl/can_flt_bank.sv
`timescale 1ns/1ps
module can_flt_bank
  import can_flt_pkg::*;
(
  input  logic              enable,
  input  logic              listMode,
  input  logic              wide,
  input  logic [DATA_W-1:0] wordA,
  input  logic [DATA_W-1:0] wordB,
  input  logic [31:0]       frame32,
  input  logic [15:0]       frame16,
  output logic [SLOTS-1:0]  hits,
  output logic [2:0]        used,
  output fltClass_t         cls
);
  always_comb begin
    hits = '0;
    used = 3'd2;
    cls  = CLS_M16;
    case ({wide, listMode})
      2'b10: begin
        used    = 3'd1;
        cls     = CLS_M32;
        hits[0] = enable && (((frame32 ^ wordA[31:0]) & wordB[31:0]) == 32'd0);
      end
      2'b11: begin
        used    = 3'd2;
        cls     = CLS_L32;
        hits[0] = enable && (frame32 == wordA[31:0]);
        hits[1] = enable && (frame32 == wordB[31:0]);
      end
      2'b00: begin
        used    = 3'd2;
        cls     = CLS_M16;
        hits[0] = enable && (((frame16 ^ wordA[15:0]) & wordA[31:16]) == 16'd0);
        hits[1] = enable && (((frame16 ^ wordB[15:0]) & wordB[31:16]) == 16'd0);
      end
      default: begin
        used    = 3'd4;
        cls     = CLS_L16;
        hits[0] = enable && (frame16 == wordA[15:0]);
        hits[1] = enable && (frame16 == wordA[31:16]);
        hits[2] = enable && (frame16 == wordB[15:0]);
        hits[3] = enable && (frame16 == wordB[31:16]);
      end
    endcase
  end
endmodule

// File: rtl/can_flt_ctrl.sv
`timescale 1ns/1ps
module can_flt_ctrl
  import can_flt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrCfgBit,
  input  logic              frmValid,
  output fltStrb_t          strb
);
  localparam logic [ADDR_W-1:0] DBASE = ADDR_W'(DATA_BASE);
  localparam logic [ADDR_W-1:0] DSPAN = ADDR_W'(DREG_NUM);

  logic              cfgMode;
  logic [ADDR_W-1:0] offs;
  logic              inData;
  logic              gated;

  always_ff @(posedge clk) begin
    if (!rstN) cfgMode <= 1'b1;
    else if (wrEn && wrAddr == ADDR_CTRL) cfgMode <= wrCfgBit;
  end

  assign offs   = wrAddr - DBASE;
  assign inData = (wrAddr >= DBASE) && (offs < DSPAN);
  assign gated  = wrEn && cfgMode;

  always_comb begin
    strb         = '0;
    strb.evalStb = frmValid;
    strb.cfgOpen = cfgMode;
    strb.enWe    = gated && (wrAddr == ADDR_EN);
    strb.fifoWe  = gated && (wrAddr == ADDR_FIFO);
    strb.styleWe = gated && (wrAddr == ADDR_STYLE);
    strb.widthWe = gated && (wrAddr == ADDR_WIDTH);
    strb.dataWe  = gated && inData;
    strb.dataSel = offs[DREG_SEL_W-1:0];
  end

  AST_CFG_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_CTRL) |=> (strb.cfgOpen == $past(wrCfgBit))) else $error("cfg"); // R1
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.enWe, strb.fifoWe, strb.styleWe, strb.widthWe, strb.dataWe})) else $error("onehot"); // R2
endmodule

// File: rtl/can_flt_datapath.sv
`timescale 1ns/1ps
module can_flt_datapath
  import can_flt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fltStrb_t          strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [STD_W-1:0]  frmStdId,
  input  logic [EXT_W-1:0]  frmExtId,
  input  logic              frmIde,
  input  logic              frmRtr,
  output logic              resValid,
  output logic              resAccept,
  output logic              resFifo,
  output logic [NUM_W-1:0]  resNum
);
  logic [NUM_BANKS-1:0]             enReg, fifoReg, listReg, wideReg;
  logic [DREG_NUM-1:0][DATA_W-1:0]  dataReg;
  logic [31:0]                      frame32;
  logic [15:0]                      frame16;
  logic [SLOTS-1:0]                 hitVec  [NUM_BANKS];
  logic [2:0]                       usedCnt [NUM_BANKS];
  fltClass_t                        clsVec  [NUM_BANKS];
  logic [NUM_W-1:0]                 baseNum [NUM_BANKS];
  logic                             found;
  fltClass_t                        bestCls;
  logic [NUM_W-1:0]                 bestNum;
  logic                             bestFifo;
  logic [NUM_W-1:0]                 candNum;
  logic                             better;
  logic                             acc;

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg   <= '0;
      fifoReg <= '0;
      listReg <= '0;
      wideReg <= '0;
      dataReg <= '0;
    end else begin
      if (strb.enWe)    enReg   <= wrData[NUM_BANKS-1:0];
      if (strb.fifoWe)  fifoReg <= wrData[NUM_BANKS-1:0];
      if (strb.styleWe) listReg <= wrData[NUM_BANKS-1:0];
      if (strb.widthWe) wideReg <= wrData[NUM_BANKS-1:0];
      if (strb.dataWe)  dataReg[strb.dataSel] <= wrData;
    end
  end

  assign frame32 = {frmStdId, frmExtId, frmIde, frmRtr, 1'b0};
  assign frame16 = {frmStdId, frmRtr, frmIde, frmExtId[EXT_W-1 -: 3]};

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    can_flt_bank u_bank (
      .enable   (enReg[b]),
      .listMode (listReg[b]),
      .wide     (wideReg[b]),
      .wordA    (dataReg[2*b]),
      .wordB    (dataReg[2*b+1]),
      .frame32  (frame32),
      .frame16  (frame16),
      .hits     (hitVec[b]),
      .used     (usedCnt[b]),
      .cls      (clsVec[b])
    );
  end

  // per-queue running filter numbers, disabled banks included
  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      baseNum[b] = '0;
      for (int j = 0; j < NUM_BANKS; j++) begin
        if (j < b && fifoReg[j] == fifoReg[b]) baseNum[b] = baseNum[b] + NUM_W'(usedCnt[j]);
      end
    end
  end

  // winner: width, then style, then number, then queue 0
  always_comb begin
    found    = 1'b0;
    bestCls  = CLS_M16;
    bestNum  = '0;
    bestFifo = 1'b0;
    candNum  = '0;
    better   = 1'b0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int k = 0; k < SLOTS; k++) begin
        candNum = baseNum[b] + NUM_W'(k);
        better  = !found || (clsVec[b] > bestCls) ||
                  (clsVec[b] == bestCls && (candNum < bestNum ||
                   (candNum == bestNum && !fifoReg[b] && bestFifo)));
        if (hitVec[b][k] && better) begin
          found    = 1'b1;
          bestCls  = clsVec[b];
          bestNum  = candNum;
          bestFifo = fifoReg[b];
        end
      end
    end
  end

  assign acc = found && !strb.cfgOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      resAccept <= 1'b0;
      resFifo   <= 1'b0;
      resNum    <= '0;
    end else if (strb.evalStb) begin
      resValid  <= 1'b1;
      resAccept <= acc;
      resFifo   <= acc ? bestFifo : 1'b0;
      resNum    <= acc ? bestNum : '0;
    end else begin
      resValid  <= 1'b0;
    end
  end

  AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strb.evalStb |=> resValid) else $error("pulse"); // R3
  AST_RESULT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(strb.evalStb)) else $error("cause"); // R3
  AST_CFG_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.evalStb && strb.cfgOpen) |=> !resAccept) else $error("blocked"); // R13
  AST_REJECT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resAccept) |-> (resNum == '0 && !resFifo)) else $error("reject"); // R12
  AST_NUM_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resAccept) |-> (resNum < NUM_W'(MAX_SLOTS))) else $error("range"); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgOpen |=> ($stable(enReg) && $stable(fifoReg) && $stable(listReg) &&
                       $stable(wideReg) && $stable(dataReg))) else $error("frozen"); // R2
endmodule

// File: rtl/can_accept_filter.sv
`timescale 1ns/1ps
module can_accept_filter
  import can_flt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              frmValid,
  input  logic [STD_W-1:0]  frmStdId,
  input  logic [EXT_W-1:0]  frmExtId,
  input  logic              frmIde,
  input  logic              frmRtr,
  output logic              resValid,
  output logic              resAccept,
  output logic              resFifo,
  output logic [NUM_W-1:0]  resMatchNum
);
  fltStrb_t strb;

  can_flt_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrCfgBit (wrData[0]),
    .frmValid (frmValid),
    .strb     (strb)
  );

  can_flt_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (wrData),
    .frmStdId  (frmStdId),
    .frmExtId  (frmExtId),
    .frmIde    (frmIde),
    .frmRtr    (frmRtr),
    .resValid  (resValid),
    .resAccept (resAccept),
    .resFifo   (resFifo),
    .resNum    (resMatchNum)
  );
endmodule

// File: tb/can_accept_filter_tb.sv
`timescale 1ns/1ps
module can_accept_filter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        frmValid = 1'b0;
  logic [10:0] frmStdId = '0;
  logic [17:0] frmExtId = '0;
  logic        frmIde = 1'b0;
  logic        frmRtr = 1'b0;
  logic        resValid, resAccept, resFifo;
  logic [7:0]  resMatchNum;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_accept_filter dut_i (.*);

  // {std11, ext18, ide, rtr, expAcc, expFifo, expNum8, req4}
  localparam int NV = 14;
  localparam logic [44:0] VECS [NV] = '{
    {11'h123, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 4'd11}, // R11 bank0 vs bank5, R4
    {11'h123, 18'h3FFFF, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 4'd4},  // R4 masked-out fields
    {11'h010, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b1, 8'd1, 4'd9},  // R9 32-bit list wins
    {11'h011, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'd2, 4'd10}, // R10 list beats mask
    {11'h013, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'd4, 4'd7},  // R7 fourth slot
    {11'h012, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b0, 8'd3, 4'd7},  // R7 third slot
    {11'h01F, 18'h00000, 1'b0, 1'b1, 1'b1, 1'b0, 8'd7, 4'd8},  // R8 disabled bank counted, R6
    {11'h300, 18'h00000, 1'b0, 1'b1, 1'b1, 1'b1, 8'd3, 4'd10}, // R10 16 list over 16 mask
    {11'h300, 18'h00000, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 4'd12}, // R12 no hit
    {11'h155, 18'h2AAAA, 1'b1, 1'b0, 1'b1, 1'b1, 8'd0, 4'd5},  // R5 extended id exact
    {11'h155, 18'h2AAAB, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 4'd5},  // R5 one bit off
    {11'h7FE, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b1, 8'd5, 4'd7},  // R7 queue 1 slot
    {11'h7FD, 18'h00000, 1'b0, 1'b0, 1'b1, 1'b1, 8'd6, 4'd8},  // R8 queue 1 count
    {11'h015, 18'h3FFFF, 1'b1, 1'b1, 1'b1, 1'b0, 8'd7, 4'd6}   // R6 16-bit mask
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // drive one frame; returns at the negedge where the result is visible
  task automatic frame(input logic [10:0] s, input logic [17:0] e, input logic i, input logic r);
    @(negedge clk);
    frmValid = 1'b1; frmStdId = s; frmExtId = e; frmIde = i; frmRtr = r;
    @(negedge clk);
    frmValid = 1'b0;
  endtask

  task automatic expectRes(input string req, input logic a, input logic f, input logic [7:0] n);
    chk(req, "valid",  {31'd0, resValid},  32'd1);
    chk(req, "accept", {31'd0, resAccept}, {31'd0, a});
    chk(req, "fifo",   {31'd0, resFifo},   {31'd0, f});
    chk(req, "num",    {24'd0, resMatchNum}, {24'd0, n});
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "valid",  {31'd0, resValid},  32'd0);
    chk("R1", "accept", {31'd0, resAccept}, 32'd0);
    chk("R1", "num",    {24'd0, resMatchNum}, 32'd0);

    // setup mode is on after reset (R1), so the bank set-up is taken (R2)
    wr(6'd1, 32'h7B);
    wr(6'd2, 32'h68);
    wr(6'd3, 32'h4A);
    wr(6'd4, 32'h29);
    wr(6'd32, 32'h24600000); wr(6'd33, 32'hFFE00000);
    wr(6'd34, 32'h02200200); wr(6'd35, 32'h02600240);
    wr(6'd36, 32'h00000000); wr(6'd37, 32'h00000000);
    wr(6'd38, 32'h2AB55554); wr(6'd39, 32'h02000000);
    wr(6'd40, 32'hFE000200); wr(6'd41, 32'hFFFF6010);
    wr(6'd42, 32'h24600000); wr(6'd43, 32'hFFE00000);
    wr(6'd44, 32'h02006010); wr(6'd45, 32'hFFA0FFC0);

    // R13 setup mode blocks acceptance
    frame(11'h123, 18'h0, 1'b0, 1'b0);
    expectRes("R13", 1'b0, 1'b0, 8'd0);

    wr(6'd0, 32'h0);
    for (int v = 0; v < NV; v++) begin
      logic [44:0] t;
      string rq;
      t = VECS[v];
      rq = $sformatf("R%0d", t[3:0]);
      frame(t[44:34], t[33:16], t[15], t[14]);
      expectRes(rq, t[13], t[12], t[11:4]);
    end

    // R3 pulse lasts one cycle
    frame(11'h011, 18'h0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R3", "pulse end", {31'd0, resValid}, 32'd0);

    // R2 writes ignored with setup mode off
    wr(6'd32, 32'h8AC00000);
    wr(6'd1, 32'h0);
    frame(11'h123, 18'h0, 1'b0, 1'b0);
    expectRes("R2", 1'b1, 1'b0, 8'd0);

    // R13 setup mode back on
    wr(6'd0, 32'h1);
    frame(11'h010, 18'h0, 1'b0, 1'b0);
    expectRes("R13", 1'b0, 1'b0, 8'd0);

    // R2 writes taken in setup mode: bank0 disabled, bank5 now wins (R11)
    wr(6'd1, 32'h7A);
    wr(6'd0, 32'h0);
    frame(11'h123, 18'h0, 1'b0, 1'b0);
    expectRes("R2", 1'b1, 1'b1, 8'd2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule